// File: doc/BRIEF.md
# I2C Block-Write Output-Enable Configuration Slave

This block is a two-wire serial slave that holds a small bank of 8-bit output-enable configuration bytes and drives them straight out as a flat vector. A bit value of 1 keeps the matching output running, and a 0 holds it low. A host programs the bank with a fixed-form block write. After the address, the host sends two bytes: a command code and a byte count. The block acknowledges both and throws them away. The data bytes that follow fill the bank from byte 0 upward. The host can read the bank back in order, starting at byte 0.

The clock and data lines are brought into the system clock domain through two-flop synchronisers. The block finds START and STOP on the synchronised lines. It runs only the plain acknowledge handshake: no clock stretching, no general call, no 10-bit addressing and no arbitration. The data line is driven open-drain through an enable output, where 1 pulls the line low.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset every configuration byte reads 8'hFF, and `sda_oe_o` is 0.
- R2: An address byte of 8'hD2 (7-bit address 7'h69 with R/W# = 0) is acknowledged and selects a write, and 8'hD3 is acknowledged and selects a read. Any other address is not acknowledged, and every byte up to the next START is ignored: no acknowledge and no register change.
- R3: In a write, every byte after a matching address is acknowledged, the command code and the byte count included.
- R4: The first two bytes after a write address are discarded. A write that stops after those two bytes leaves every register unchanged.
- R5: Data bytes load register 0, then 1, then 2, in that order, and register k appears on `cfg_o[8k+7:8k]`. A write may stop after any whole byte, and the registers it has not reached keep their values.
- R6: Data bytes beyond the last register are acknowledged and dropped.
- R7: A read returns the registers starting at byte 0, most significant bit first, moving to the next register after each byte the master acknowledges. After the last register it wraps to byte 0.
- R8: A NACK from the master during a read ends the transfer. SDA is released and stays released until the next START.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP releases SDA and returns the slave to idle. A repeated START begins a new address phase without a STOP in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_o | output | 8*NUM_REGS | Configuration bytes, register k on bits 8k+7..8k |

## Verification
The bench mixes seeded random block writes with random data lengths, from zero up to past the end of the bank. This separates partial writes, full writes and overflow writes, and shows whether the two header bytes are really discarded. Random-length reads, always ending on a NACK, show whether the read starts at byte 0 and whether it wraps. A wrong address followed by extra bytes shows whether the slave stays silent. A write followed by a repeated START into a read shows that the slave re-enters the address phase without a STOP.

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter int NUM_REGS = 3,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_WR, S_RD} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rw;
  logic [1:0] skip;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic       wr_full;
  logic [7:0] regs [NUM_REGS];

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire scl_rise = ~scl_q & scl_s;
  wire scl_fall = scl_q & ~scl_s;
  wire start_det = scl_q & scl_s & sda_q & ~sda_s;
  wire stop_det  = scl_q & scl_s & ~sda_q & sda_s;
  wire [PTR_W-1:0] rd_next = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign cfg_o[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      rw       <= 1'b0;
      skip     <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      wr_full  <= 1'b0;
      sda_oe_o <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= 8'hFF;
    end else if (start_det) begin
      st       <= S_ADDR;
      cnt      <= '0;
      skip     <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      wr_full  <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      st       <= S_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: ;
        S_ADDR, S_WR: begin
          if (scl_rise && cnt < 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= 4'd9;
            if (st == S_ADDR) begin
              if (sh[7:1] == DEV_ADDR) begin
                sda_oe_o <= 1'b1;
                rw       <= sh[0];
              end else begin
                st <= S_IDLE;
              end
            end else begin
              sda_oe_o <= 1'b1;
              if (skip != 2'd2) begin
                skip <= skip + 2'd1;
              end else if (!wr_full) begin
                regs[wr_ptr] <= sh;
                if (wr_ptr == LAST) wr_full <= 1'b1;
                else wr_ptr <= wr_ptr + 1'b1;
              end
            end
          end else if (scl_fall && cnt == 4'd9) begin
            cnt <= '0;
            if (st == S_ADDR && rw) begin
              st       <= S_RD;
              sh       <= regs[rd_ptr];
              sda_oe_o <= ~regs[rd_ptr][7];
              rd_ptr   <= rd_next;
            end else begin
              st       <= S_WR;
              sda_oe_o <= 1'b0;
            end
          end
        end
        S_RD: begin
          if (scl_rise) begin
            if (cnt == 4'd8) begin
              if (sda_s) st <= S_IDLE;
              else cnt <= 4'd9;
            end else if (cnt < 4'd8) begin
              cnt <= cnt + 4'd1;
            end
          end else if (scl_fall) begin
            if (cnt == 4'd9) begin
              cnt      <= '0;
              sh       <= regs[rd_ptr];
              sda_oe_o <= ~regs[rd_ptr][7];
              rd_ptr   <= rd_next;
            end else if (cnt == 4'd8) begin
              sda_oe_o <= 1'b0;
            end else if (cnt != 4'd0) begin
              sh       <= {sh[6:0], 1'b0};
              sda_oe_o <= ~sh[6];
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1/R8: nothing drives the line while idle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !sda_oe_o);

  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == S_IDLE && !sda_oe_o));

  p_start_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_ADDR && cnt == 4'd0));

  p_nack_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && scl_rise && cnt == 4'd8 && sda_s) |=> st == S_IDLE);

  // R5: registers change only while a write is in progress
  p_cfg_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(st) == S_WR);

  p_no_drive_scl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && scl_s && !start_det) |=> $stable(sda_oe_o) || st == S_IDLE);
endmodule

// File: tb/i2c_cfg_slave_tb.sv
module i2c_cfg_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_REGS = 3;
  localparam int Q = 5;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NUM_REGS*8-1:0] cfg;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model [NUM_REGS];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cfg_slave #(.NUM_REGS(NUM_REGS), .DEV_ADDR(7'h69)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .cfg_o(cfg)
  );

  function automatic logic [NUM_REGS*8-1:0] exp_cfg();
    logic [NUM_REGS*8-1:0] v;
    for (int i = 0; i < NUM_REGS; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(int k);
    return model[k % NUM_REGS];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); b = sda_line; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic do_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic tx_byte(input logic [7:0] d, output logic nak);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(nak);
  endtask

  task automatic rx_byte(input logic last, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(last);
  endtask

  task automatic block_write(input int n, input logic do_stop_after);
    logic nak;
    do_start();
    tx_byte(8'hD2, nak); chk("R2 write address ack", nak, 0);
    tx_byte(8'($urandom), nak); chk("R3 command ack", nak, 0);
    tx_byte(8'($urandom), nak); chk("R3 count ack", nak, 0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'($urandom);
      tx_byte(d, nak);
      if (i < NUM_REGS) begin
        model[i] = d;
        chk("R3 data ack", nak, 0);
      end else begin
        chk("R6 overflow ack", nak, 0);
      end
    end
    if (do_stop_after) do_stop();
  endtask

  task automatic block_read(input int n);
    logic nak;
    logic [7:0] d;
    do_start();
    tx_byte(8'hD3, nak); chk("R2 read address ack", nak, 0);
    for (int k = 0; k < n; k++) begin
      rx_byte(k == n - 1, d);
      chk("R7 read data", d, exp_rd(k));
    end
    repeat (4) @(negedge clk);
    chk("R8 released after nack", sda_oe, 0);
    do_stop();
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic nak;
    void'($urandom(32'd1234));
    for (int i = 0; i < NUM_REGS; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset cfg", 32'(cfg), 32'(exp_cfg()));
    chk("R1 reset sda_oe", sda_oe, 0);

    block_write(0, 1'b1);
    chk("R4 header only", 32'(cfg), 32'(exp_cfg()));

    block_write(1, 1'b1);
    chk("R5 partial write", 32'(cfg), 32'(exp_cfg()));

    do_start();
    tx_byte(8'hA2, nak); chk("R2 wrong address nack", nak, 1);
    for (int i = 0; i < 3; i++) begin
      tx_byte(8'h00, nak); chk("R2 ignored byte nack", nak, 1);
    end
    do_stop();
    chk("R2 cfg untouched", 32'(cfg), 32'(exp_cfg()));

    block_write(NUM_REGS + 2, 1'b1);
    chk("R6 overflow write", 32'(cfg), 32'(exp_cfg()));

    block_write(2, 1'b0);
    chk("R9 cfg before repeated start", 32'(cfg), 32'(exp_cfg()));
    block_read(NUM_REGS + 2);

    block_read(1);
    repeat (20) @(negedge clk);
    chk("R8 idle after read", sda_oe, 0);

    for (int it = 0; it < 25; it++) begin
      int n = $urandom_range(0, NUM_REGS + 2);
      block_write(n, 1'b1);
      chk("R5 random write", 32'(cfg), 32'(exp_cfg()));
      block_read($urandom_range(1, NUM_REGS + 2));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule